// File: doc/BRIEF.md
# Affine Index Dependence Screen

This block decides whether a store and a later load of the same array, inside a counted loop, can ever touch the same element. The store index has the form a*i+b and the load index has the form c*i+d. The four coefficients are signed integer constants. A dependence carried from one iteration to a later one needs two iteration numbers j<k with a*j+b = c*k+d. Such a pair can exist only if the greatest common divisor of |a| and |c| divides (d-b). The block computes that divisor and runs the divisibility test. It does not look at loop bounds, so a positive answer means a dependence is possible, not that one is certain.

A caller offers the four coefficients with `start_valid` while `start_ready` is high. The block accepts them on that edge and keeps its own copy, so it ignores the coefficient inputs while the job runs. `start_ready` is the only back-pressure: it stays low while a job is in flight, and `start_valid` has no effect during that time. The divisor is found by Euclidean subtraction, one step per clock. The divisibility test then runs as a restoring remainder, one bit per clock. At the end the block raises `done_valid` for exactly one cycle. The result does not wait on the caller: `dep_possible` and `gcd_value` keep their values until the next job completes.

Top module: `dep_gcd_tester`

## Requirements
- R1: After reset, start_ready is 1 and busy, done_valid, dep_possible and gcd_value are all 0.
- R2: A job starts on a clock edge where start_valid and start_ready are both 1. Changes on coef_a..coef_d, and a start_valid held high, have no effect on a job that is already running.
- R3: start_ready is 0 from the cycle after acceptance until the cycle in which done_valid is 1. In that cycle start_ready is 1 again.
- R4: gcd_value is the greatest common divisor of |coef_a| and |coef_c|, as an unsigned CW-bit value.
- R5: When gcd_value is nonzero, dep_possible is 1 exactly when gcd_value divides the magnitude of (coef_d - coef_b). The difference is formed at CW+1 bits, so it cannot overflow.
- R6: When coef_a and coef_c are both 0, gcd_value is 0 and dep_possible is 1 exactly when coef_b equals coef_d.
- R7: When exactly one of coef_a and coef_c is 0, gcd_value is the magnitude of the other one.
- R8: done_valid is a single-cycle pulse. dep_possible and gcd_value change only in a done_valid cycle.
- R9: The most negative coefficient, -2^(CW-1), is taken as the magnitude 2^(CW-1).
- R10: done_valid rises no later than max(|a|,|c|)+CW+3 clock edges after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Coefficients offered |
| start_ready | output | 1 | Block idle, able to accept a job |
| coef_a | input | CW | Store index multiplier (signed) |
| coef_b | input | CW | Store index offset (signed) |
| coef_c | input | CW | Load index multiplier (signed) |
| coef_d | input | CW | Load index offset (signed) |
| busy | output | 1 | Job in flight |
| done_valid | output | 1 | One-cycle completion pulse |
| dep_possible | output | 1 | Dependence cannot be ruled out |
| gcd_value | output | CW | GCD of the two multiplier magnitudes |

## Verification
The bench builds two copies of the block. The first uses CW=4. With this width every pairing of the two multipliers over -8..7 runs against six offset pairs. Those pairs give positive, negative, zero and extreme differences. This sweep covers every zero-multiplier case, every most-negative-value case and every GCD path. The second copy uses the default CW=16. It takes directed jobs at the full range, including -32768 against 1, which is the longest subtraction run, and an offset difference of 65535.

// File: rtl/gcd_dep_pkg.sv
package gcd_dep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GCD  = 2'd1,
    ST_DIV  = 2'd2
  } tester_state_t;
endpackage

// File: rtl/coef_prep.sv
// Turns the signed coefficients into the magnitudes the engines work on.
module coef_prep #(
  parameter int CW = 16
) (
  input  logic signed [CW-1:0] a_in,
  input  logic signed [CW-1:0] b_in,
  input  logic signed [CW-1:0] c_in,
  input  logic signed [CW-1:0] d_in,
  output logic [CW-1:0]        a_mag,
  output logic [CW-1:0]        c_mag,
  output logic [CW:0]          diff_mag,
  output logic                 diff_zero
);
  localparam int DW = CW + 1;

  logic signed [DW-1:0] diff_s;

  // Two's complement negate; -2^(CW-1) comes out as the unsigned 2^(CW-1).
  assign a_mag = a_in[CW-1] ? (~a_in + 1'b1) : a_in;
  assign c_mag = c_in[CW-1] ? (~c_in + 1'b1) : c_in;

  // Sign-extend both offsets by one bit so the subtraction cannot overflow.
  assign diff_s    = {d_in[CW-1], d_in} - {b_in[CW-1], b_in};
  assign diff_mag  = diff_s[DW-1] ? (~diff_s + 1'b1) : diff_s;
  assign diff_zero = (diff_s == '0);
endmodule

// File: rtl/gcd_engine.sv
// Euclidean subtraction: takes one step per clock until either operand is zero.
module gcd_engine #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  output logic         fin,
  output logic [W-1:0] result
);
  logic [W-1:0] x_q, y_q;

  assign fin    = (x_q == '0) || (y_q == '0);
  // When fin is 1 one operand is zero, so OR gives the other one.
  assign result = x_q | y_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (load) begin
      x_q <= x_in;
      y_q <= y_in;
    end else if (!fin) begin
      if (x_q >= y_q) x_q <= x_q - y_q;
      else            y_q <= y_q - x_q;
    end
  end
endmodule

// File: rtl/rem_unit.sv
// Restoring remainder: one dividend bit per clock, NW clocks per job.
// The divisor input must stay stable while the job runs.
module rem_unit #(
  parameter int NW  = 17,
  parameter int DVW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [NW-1:0]  dividend,
  input  logic [DVW-1:0] divisor,
  output logic           fin,
  output logic [DVW-1:0] remainder
);
  localparam int CNTW = $clog2(NW + 1);

  logic [DVW-1:0]  rem_q;
  logic [NW-1:0]   shift_q;
  logic [CNTW-1:0] cnt_q;
  logic [DVW:0]    trial;
  logic [DVW:0]    trial_sub;
  logic            take;

  assign trial     = {rem_q, shift_q[NW-1]};
  assign take      = (trial >= {1'b0, divisor});
  assign trial_sub = trial - {1'b0, divisor};
  assign fin       = (cnt_q == '0);
  assign remainder = rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q   <= '0;
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (load) begin
      rem_q   <= '0;
      shift_q <= dividend;
      cnt_q   <= CNTW'(NW);
    end else if (!fin) begin
      rem_q   <= take ? trial_sub[DVW-1:0] : trial[DVW-1:0];
      shift_q <= shift_q << 1;
      cnt_q   <= cnt_q - CNTW'(1);
    end
  end
endmodule

// File: rtl/dep_gcd_tester.sv
module dep_gcd_tester
  import gcd_dep_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_valid,
  output logic                 start_ready,
  input  logic signed [CW-1:0] coef_a,
  input  logic signed [CW-1:0] coef_b,
  input  logic signed [CW-1:0] coef_c,
  input  logic signed [CW-1:0] coef_d,
  output logic                 busy,
  output logic                 done_valid,
  output logic                 dep_possible,
  output logic [CW-1:0]        gcd_value
);
  localparam int DW = CW + 1;

  tester_state_t state_q;

  logic [CW-1:0] a_mag, c_mag;
  logic [DW-1:0] diff_mag;
  logic          diff_zero;
  logic [DW-1:0] diff_mag_q;
  logic          diff_zero_q;

  logic          accept;
  logic          gcd_fin;
  logic [CW-1:0] gcd_res;
  logic          div_load;
  logic          div_fin;
  logic [CW-1:0] div_rem;

  assign start_ready = (state_q == ST_IDLE);
  assign busy        = !start_ready;
  assign accept      = start_valid && start_ready;
  // The divider starts only when the GCD is nonzero; a zero GCD skips it.
  assign div_load    = (state_q == ST_GCD) && gcd_fin && (gcd_res != '0);

  coef_prep #(.CW(CW)) u_prep (
    .a_in      (coef_a),
    .b_in      (coef_b),
    .c_in      (coef_c),
    .d_in      (coef_d),
    .a_mag     (a_mag),
    .c_mag     (c_mag),
    .diff_mag  (diff_mag),
    .diff_zero (diff_zero)
  );

  gcd_engine #(.W(CW)) u_gcd (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .x_in   (a_mag),
    .y_in   (c_mag),
    .fin    (gcd_fin),
    .result (gcd_res)
  );

  // The GCD engine holds its result while in ST_DIV, so it serves as the divisor.
  rem_unit #(.NW(DW), .DVW(CW)) u_rem (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (div_load),
    .dividend  (diff_mag_q),
    .divisor   (gcd_res),
    .fin       (div_fin),
    .remainder (div_rem)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      diff_mag_q   <= '0;
      diff_zero_q  <= 1'b0;
      done_valid   <= 1'b0;
      dep_possible <= 1'b0;
      gcd_value    <= '0;
    end else begin
      done_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            diff_mag_q  <= diff_mag;
            diff_zero_q <= diff_zero;
            state_q     <= ST_GCD;
          end
        end
        ST_GCD: begin
          if (gcd_fin) begin
            if (gcd_res == '0) begin
              dep_possible <= diff_zero_q;
              gcd_value    <= '0;
              done_valid   <= 1'b1;
              state_q      <= ST_IDLE;
            end else begin
              state_q <= ST_DIV;
            end
          end
        end
        ST_DIV: begin
          if (div_fin) begin
            dep_possible <= (div_rem == '0);
            gcd_value    <= gcd_res;
            done_valid   <= 1'b1;
            state_q      <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gcd_dep_checker.sv
module gcd_dep_checker #(
  parameter int CW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start_valid,
  input logic                 start_ready,
  input logic signed [CW-1:0] coef_a,
  input logic signed [CW-1:0] coef_b,
  input logic signed [CW-1:0] coef_c,
  input logic signed [CW-1:0] coef_d,
  input logic                 done_valid,
  input logic                 dep_possible,
  input logic [CW-1:0]        gcd_value
);
  localparam int LIM = 2 ** (CW - 1) + CW + 3;

  logic [CW-1:0]        ma_q, mc_q;
  logic signed [CW:0]   dd_q;
  logic [CW:0]          dmag;
  logic [31:0]          busy_cnt;

  assign dmag = dd_q[CW] ? (-dd_q) : dd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ma_q     <= '0;
      mc_q     <= '0;
      dd_q     <= '0;
      busy_cnt <= '0;
    end else if (start_valid && start_ready) begin
      ma_q     <= coef_a[CW-1] ? CW'(-coef_a) : coef_a;
      mc_q     <= coef_c[CW-1] ? CW'(-coef_c) : coef_c;
      dd_q     <= $signed({coef_d[CW-1], coef_d}) - $signed({coef_b[CW-1], coef_b});
      busy_cnt <= 32'd1;
    end else if (!start_ready) begin
      busy_cnt <= busy_cnt + 32'd1;
    end
  end

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_valid |-> ($stable(gcd_value) && $stable(dep_possible)));

  a_r3_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> !start_ready);

  a_r3_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> start_ready);

  a_r4_gcd_divides: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && gcd_value != '0) |-> ((ma_q % gcd_value) == '0 && (mc_q % gcd_value) == '0));

  a_r5_divisibility: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && gcd_value != '0) |-> (dep_possible == ((dmag % {1'b0, gcd_value}) == '0)));

  a_r6_both_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && ma_q == '0 && mc_q == '0) |-> (gcd_value == '0 && dep_possible == (dd_q == '0)));

  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    !start_ready |-> (busy_cnt <= 32'(LIM)));
endmodule

bind dep_gcd_tester gcd_dep_checker #(.CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_valid  (start_valid),
  .start_ready  (start_ready),
  .coef_a       (coef_a),
  .coef_b       (coef_b),
  .coef_c       (coef_c),
  .coef_d       (coef_d),
  .done_valid   (done_valid),
  .dep_possible (dep_possible),
  .gcd_value    (gcd_value)
);

// File: tb/dep_gcd_tester_tb.sv
module dep_gcd_tester_tb;
  localparam int SW = 4;
  localparam int FW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          s_valid = 0, f_valid = 0;
  logic [SW-1:0] s_a = '0, s_b = '0, s_c = '0, s_d = '0;
  logic [FW-1:0] f_a = '0, f_b = '0, f_c = '0, f_d = '0;
  logic          s_ready, s_busy, s_done, s_dep;
  logic          f_ready, f_busy, f_done, f_dep;
  logic [SW-1:0] s_gcd;
  logic [FW-1:0] f_gcd;

  int n_chk = 0;
  int n_fail = 0;

  dep_gcd_tester #(.CW(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_valid(s_valid), .start_ready(s_ready),
    .coef_a(s_a), .coef_b(s_b), .coef_c(s_c), .coef_d(s_d),
    .busy(s_busy), .done_valid(s_done), .dep_possible(s_dep), .gcd_value(s_gcd));

  dep_gcd_tester #(.CW(FW)) u_dut_full (
    .clk(clk), .rst_n(rst_n), .start_valid(f_valid), .start_ready(f_ready),
    .coef_a(f_a), .coef_b(f_b), .coef_c(f_c), .coef_d(f_d),
    .busy(f_busy), .done_valid(f_done), .dep_possible(f_dep), .gcd_value(f_gcd));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int ref_gcd(input int x, input int y);
    int p = iabs(x);
    int q = iabs(y);
    while (q != 0) begin
      int t = p % q;
      p = q;
      q = t;
    end
    return p;
  endfunction

  function automatic bit ref_dep(input int a, input int b, input int c, input int d);
    int g = ref_gcd(a, c);
    if (g == 0) return (b == d);
    return ((d - b) % g) == 0;
  endfunction

  task automatic drive(input bit full, input int a, input int b, input int c, input int d);
    if (full) begin
      f_a = FW'(a); f_b = FW'(b); f_c = FW'(c); f_d = FW'(d);
    end else begin
      s_a = SW'(a); s_b = SW'(b); s_c = SW'(c); s_d = SW'(d);
    end
  endtask

  task automatic set_valid(input bit full, input bit v);
    if (full) f_valid = v; else s_valid = v;
  endtask

  task automatic run_case(input bit full, input int a, input int b, input int c, input int d,
                          input bit hold);
    int  eg = ref_gcd(a, c);
    bit  ed = ref_dep(a, b, c, d);
    int  w = full ? FW : SW;
    int  lim = ((iabs(a) > iabs(c)) ? iabs(a) : iabs(c)) + w + 3;
    int  cyc = 0;
    int  g_got;
    bit  d_got;
    @(negedge clk);
    drive(full, a, b, c, d);
    set_valid(full, 1'b1);
    @(posedge clk);
    @(negedge clk);
    // R3: ready drops the cycle after acceptance
    chk((full ? f_ready : s_ready) == 1'b0, "R3 ready low while busy",
        int'(full ? f_ready : s_ready), 0);
    // R2: disturb the inputs; a held valid must not start a second job
    drive(full, ~a, ~b, ~c, ~d);
    if (!hold) set_valid(full, 1'b0);
    forever begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if ((full ? f_done : s_done) || cyc > 40000) break;
    end
    if (hold) set_valid(full, 1'b0);
    g_got = full ? int'(f_gcd) : int'(s_gcd);
    d_got = full ? f_dep : s_dep;
    chk(g_got == eg, hold ? "R2 R4 gcd with valid held" : "R4 gcd value", g_got, eg);
    chk(d_got == ed, hold ? "R2 R5 dep with valid held" : "R5 dependence flag", int'(d_got), int'(ed));
    chk(cyc <= lim, "R10 latency bound", cyc, lim);
    chk((full ? f_ready : s_ready) == 1'b1, "R3 ready with done", 0, 1);
    @(negedge clk);
    chk((full ? f_done : s_done) == 1'b0, "R8 done single pulse", 1, 0);
    g_got = full ? int'(f_gcd) : int'(s_gcd);
    chk(g_got == eg && (full ? f_dep : s_dep) == ed, "R8 results held", g_got, eg);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int bd [6][2] = '{'{3, 0}, '{0, 0}, '{-8, 7}, '{7, -8}, '{5, -1}, '{-4, 2}};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(s_ready && !s_busy && !s_done && !s_dep && s_gcd == '0, "R1 reset state small",
        int'(s_gcd), 0);
    chk(f_ready && !f_busy && !f_done && !f_dep && f_gcd == '0, "R1 reset state full",
        int'(f_gcd), 0);
    rst_n = 1'b1;

    // Directed, full width
    run_case(1, 2, 3, 2, 0, 0);                 // R5 odd difference, no dependence
    run_case(1, -32768, 0, 1, 5, 0);            // R9 most negative against 1
    run_case(1, -32768, -32768, -32768, 32767, 0); // R9 gcd 32768, difference 65535
    run_case(1, 0, 4, 0, 4, 0);                 // R6 both zero, equal offsets
    run_case(1, 0, 4, 0, 5, 0);                 // R6 both zero, unequal offsets
    run_case(1, 0, 0, -12, -6, 0);              // R7 one zero
    run_case(1, 3, 100, 0, -200, 0);            // R7 other zero, negative difference
    run_case(1, 12, 1, -18, 7, 0);              // R5 divides
    run_case(1, 12, -32768, -18, 32767, 1);     // R2 valid held during job

    // Exhaustive multipliers at 4 bits against offset pairs (R4 R5 R6 R7 R9)
    for (int a = -8; a < 8; a++)
      for (int c = -8; c < 8; c++)
        for (int k = 0; k < 6; k++)
          run_case(0, a, bd[k][0], c, bd[k][1], (a == 5 && c == -3));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule